// File: doc/BRIEF.md
# Programmable Priority Bus Arbiter

This block is a central bus arbiter for a parameterised number of masters. Each master drives a request line and receives a grant line. Each master also owns a priority value that software programs through a small register write port inside the block. Within the same bus cycle, the block grants the bus to the requesting master whose programmed priority is numerically largest. When two such masters hold equal priorities, the lower master index wins.

When no master requests, the grant is parked on the master that currently holds the largest programmed priority, using the same lowest-index rule for ties. That master can therefore start a transfer without first raising its request.

Requests and the programmed values are turned into compare keys. The request bit sits above the priority bits, so any requester outranks any idle master. A balanced tree of two-input compare-and-select nodes, log2 of the master count deep, reduces these keys to one winner. The winner's index is then decoded into a one-hot grant vector. The grant path is purely combinational from the request inputs. Only the priority values are held in flops.

Top module: `prio_arbiter`

## Requirements
- R1: After reset every programmed priority is 0. With no writes since reset, the grant goes to the lowest-index requester, or to master 0 when nobody requests.
- R2: A write with `wrEn` high at a rising clock edge stores `wrData` as the priority of master `wrIdx`. The new value affects `gnt` from that edge onward and not before it. A write whose index is not below the master count changes nothing.
- R3: When at least one request is high, the granted master is a requester whose priority is not smaller than that of any other requester.
- R4: Among requesters that share the largest priority, the one with the lowest index is granted.
- R5: A requester with priority 0 is granted ahead of every non-requesting master, whatever priorities the non-requesters hold.
- R6: With all requests low, the grant goes to the master with the largest programmed priority. Among masters that share that priority, the one with the lowest index is granted.
- R7: After reset, `gnt` always has exactly one bit set. Bit i of `gnt` stands for master i.
- R8: `gnt` depends only on the present `req` and the stored priorities. It changes within the cycle in which `req` changes, and it holds still while `req` and the priorities hold still.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset of the priority registers |
| req | input | NUM_MASTERS | Request lines, bit i from master i |
| wrEn | input | 1 | Priority register write strobe |
| wrIdx | input | clog2(NUM_MASTERS) | Master whose priority is written |
| wrData | input | clog2(NUM_MASTERS) | Priority value to store |
| gnt | output | NUM_MASTERS | One-hot grant, bit i to master i |

## Verification
The bench programs priorities that collide on purpose. It then checks that ties between requesters, and ties while parked, resolve to the lower index. A tree node that favoured the wrong subtree on equal keys would hand the bus to a higher-index master. A requester at priority 0 is set against idle masters at priority 15. This catches a key that dropped the request bit, which would grant an idle master. A write is timed against the clock edge to show that the grant moves only after the edge. A long randomised run then compares every grant with a sequential scan over all masters.

// File: rtl/arb_pkg.sv
package arb_pkg;
  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic wrStrobe;  // a valid priority write this cycle
    logic parkAll;   // no request pending: treat every master as requesting
  } arb_strobe_t;
endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl #(
  parameter int NUM_MASTERS = 16,
  localparam int PRIO_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_MASTERS-1:0]  req,
  input  logic                    wrEn,
  input  logic [PRIO_W-1:0]       wrIdx,
  output arb_pkg::arb_strobe_t    strb
);
  localparam int IDX_LIMIT = NUM_MASTERS;

  logic idxInRange;

  always_comb begin
    idxInRange    = (32'(wrIdx) < IDX_LIMIT);
    strb.wrStrobe = wrEn && idxInRange;
    strb.parkAll  = (req == '0);
  end

  // R2: an out-of-range index never produces a write strobe
  p_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wrStrobe |-> (32'(wrIdx) < NUM_MASTERS));

endmodule

// File: rtl/arb_max_tree.sv
module arb_max_tree #(
  parameter int NUM_MASTERS = 16,
  localparam int PRIO_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1,
  localparam int KEY_W  = PRIO_W + 1,
  localparam int LEVELS = PRIO_W,
  localparam int LEAVES = 1 << LEVELS
) (
  input  logic [NUM_MASTERS-1:0][KEY_W-1:0] leafKey,
  output logic [PRIO_W-1:0]                 winIdx
);
  for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
    localparam int WIDTH = LEAVES >> l;
    logic [KEY_W-1:0]  key [WIDTH];
    logic [PRIO_W-1:0] idx [WIDTH];

    if (l == 0) begin : g_leaf
      for (genvar j = 0; j < WIDTH; j++) begin : g_in
        if (j < NUM_MASTERS) begin : g_real
          assign key[j] = leafKey[j];
        end else begin : g_pad
          // padding leaf: all-zero key, only ever ties and then loses on index
          assign key[j] = '0;
        end
        assign idx[j] = PRIO_W'(j);
      end
    end else begin : g_node
      for (genvar n = 0; n < WIDTH; n++) begin : g_cmp
        logic takeHigh;
        // strict compare: on equal keys the lower-index subtree passes on
        assign takeHigh = g_lvl[l-1].key[2*n+1] > g_lvl[l-1].key[2*n];
        assign key[n] = takeHigh ? g_lvl[l-1].key[2*n+1] : g_lvl[l-1].key[2*n];
        assign idx[n] = takeHigh ? g_lvl[l-1].idx[2*n+1] : g_lvl[l-1].idx[2*n];
      end
    end
  end

  assign winIdx = g_lvl[LEVELS].idx[0];

endmodule

// File: rtl/arb_datapath.sv
module arb_datapath #(
  parameter int NUM_MASTERS = 16,
  localparam int PRIO_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1,
  localparam int KEY_W  = PRIO_W + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_MASTERS-1:0] req,
  input  logic [PRIO_W-1:0]      wrIdx,
  input  logic [PRIO_W-1:0]      wrData,
  input  arb_pkg::arb_strobe_t   strb,
  output logic [NUM_MASTERS-1:0] gnt
);
  logic [PRIO_W-1:0]                 prioReg [NUM_MASTERS];
  logic [NUM_MASTERS-1:0][KEY_W-1:0] leafKey;
  logic [PRIO_W-1:0]                 winIdx;

  // priority register bank
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_MASTERS; i++) prioReg[i] <= '0;
    end else if (strb.wrStrobe) begin
      prioReg[wrIdx] <= wrData;
    end
  end

  // compare keys: request bit above the programmed priority
  for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_key
    assign leafKey[i] = {req[i] | strb.parkAll, prioReg[i]};
  end

  arb_max_tree #(.NUM_MASTERS(NUM_MASTERS)) u_tree (
    .leafKey (leafKey),
    .winIdx  (winIdx)
  );

  // one-hot decode of the winning index
  always_comb begin
    for (int i = 0; i < NUM_MASTERS; i++) gnt[i] = (winIdx == PRIO_W'(i));
  end

  // R2: a strobed write lands in the addressed register at the edge
  p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wrStrobe |=> (prioReg[$past(wrIdx)] == $past(wrData)));

  // R7: exactly one grant at all times
  p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gnt) == 1);

  // R5: with any request pending the grant lands on a requester
  p_requester_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |-> ((gnt & req) != '0));

  // R8: grant holds while requests and priorities hold
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(req) && !$past(strb.wrStrobe)) |-> $stable(gnt));

endmodule

// File: rtl/prio_arbiter.sv
module prio_arbiter #(
  parameter int NUM_MASTERS = 16,
  localparam int PRIO_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_MASTERS-1:0] req,
  input  logic                   wrEn,
  input  logic [PRIO_W-1:0]      wrIdx,
  input  logic [PRIO_W-1:0]      wrData,
  output logic [NUM_MASTERS-1:0] gnt
);
  arb_pkg::arb_strobe_t strb;

  arb_ctrl #(.NUM_MASTERS(NUM_MASTERS)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .wrEn  (wrEn),
    .wrIdx (wrIdx),
    .strb  (strb)
  );

  arb_datapath #(.NUM_MASTERS(NUM_MASTERS)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (req),
    .wrIdx  (wrIdx),
    .wrData (wrData),
    .strb   (strb),
    .gnt    (gnt)
  );

endmodule

// File: tb/prio_arbiter_tb.sv
module prio_arbiter_tb;
  localparam int N = 16;
  localparam int W = 4;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  // table walked with priorities: m3=9, m7=9, m10=15, m12=2, others 0
  localparam logic [N-1:0] VEC_REQ [NVEC] = '{
    16'h0000, 16'h0088, 16'h0488, 16'h0003,
    16'h1001, 16'h8000, 16'h8080, 16'hFFFF};
  localparam logic [N-1:0] VEC_GNT [NVEC] = '{
    16'h0400, 16'h0008, 16'h0400, 16'h0001,
    16'h1000, 16'h8000, 16'h0080, 16'h0400};
  localparam string VEC_TAG [NVEC] = '{
    "R6", "R4", "R3", "R4", "R3", "R5", "R3", "R3"};

  logic clk = 0;
  logic rst_n = 0;
  logic [N-1:0] req = '0;
  logic wrEn = 0;
  logic [W-1:0] wrIdx = '0;
  logic [W-1:0] wrData = '0;
  logic [N-1:0] gnt;

  int nChecks = 0;
  int nFails = 0;
  logic [W-1:0] shadow [N];

  prio_arbiter #(.NUM_MASTERS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .wrEn(wrEn),
    .wrIdx(wrIdx), .wrData(wrData), .gnt(gnt));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [N-1:0] refGrant(input logic [N-1:0] r);
    logic [N-1:0] eff;
    int best;
    logic [W:0] bestKey, k;
    eff = (r == '0) ? '1 : r;
    best = 0;
    bestKey = {eff[0], shadow[0]};
    for (int i = 1; i < N; i++) begin
      k = {eff[i], shadow[i]};
      if (k > bestKey) begin best = i; bestKey = k; end
    end
    return N'(1) << best;
  endfunction

  task automatic check(input string tag, input logic [N-1:0] exp);
    nChecks++;
    if (gnt !== exp) begin
      nFails++;
      $display("FAIL %s req=%h gnt=%h expected=%h", tag, req, gnt, exp);
    end
  endtask

  // drive a write at the negedge; it takes effect at the next posedge
  task automatic writePrio(input int idx, input logic [W-1:0] val);
    @(negedge clk);
    wrEn = 1; wrIdx = W'(idx); wrData = val;
    @(posedge clk);
    #1 wrEn = 0;
    if (idx < N) shadow[idx] = val;
  endtask

  task automatic applyReq(input logic [N-1:0] r);
    @(negedge clk);
    req = r;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) shadow[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: reset priorities all zero
    applyReq(16'h0000); check("R1 park after reset", 16'h0001);
    applyReq(16'h0600); check("R1 lowest requester", 16'h0200);
    check("R7 one-hot", refGrant(req));

    // program the table's priority set
    writePrio(3, 4'd9);
    writePrio(7, 4'd9);
    writePrio(10, 4'd15);
    writePrio(12, 4'd2);

    for (int v = 0; v < NVEC; v++) begin
      applyReq(VEC_REQ[v]);
      check(VEC_TAG[v], VEC_GNT[v]);
    end

    // R2: write timing, grant moves only after the edge
    applyReq(16'h0408);
    check("R2 before write", 16'h0400);
    @(negedge clk);
    wrEn = 1; wrIdx = 4'd10; wrData = 4'd3;
    #1 check("R2 same cycle as strobe", 16'h0400);
    @(posedge clk);
    #1 wrEn = 0;
    shadow[10] = 4'd3;
    check("R2 after edge", 16'h0008);

    // R6: parked grant with a tie among the top priority
    applyReq(16'h0000); check("R6 park tie", 16'h0008);

    // R5: zero-priority requester against idle high-priority masters
    writePrio(0, 4'd15);
    applyReq(16'h4000); check("R5 prio0 requester", 16'h4000);
    applyReq(16'h0000); check("R6 park highest", 16'h0001);

    // R8: combinational response and hold
    applyReq(16'h0080); check("R8 immediate", 16'h0080);
    @(negedge clk); #1 check("R8 hold", 16'h0080);

    // random run against a sequential scan
    for (int t = 0; t < 400; t++) begin
      if (($urandom % 3) == 0) writePrio($urandom % N, W'($urandom));
      case ($urandom % 4)
        0: applyReq('0);
        1: applyReq(N'(1) << ($urandom % N));
        default: applyReq(N'($urandom));
      endcase
      check("R3 random", refGrant(req));
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule